// File: doc/BRIEF.md
# Handshaked Seven-Bit Serial Character Transmitter

This block sends one 7-bit character at a time onto an asynchronous serial line. Each character goes out in a fixed ten-bit frame:
- a low start bit,
- the seven data bits, least significant first,
- one parity bit,
- a high stop bit.

Every bit lasts the same fixed number of clock cycles, set by a parameter. A parity-select input chooses whether the parity bit makes the count of ones odd or even.

The host uses a four-phase request/acknowledge exchange:
1. The host raises `send` and holds it.
2. The transmitter answers with `busy` and captures the character and the parity choice.
3. The transmitter drops `busy` only when the stop bit has been fully sent.
4. The transmitter will not take a new request until the host has released `send`.

Inside the block:
- a bit-period timer produces one tick per bit time;
- a modulo-10 position counter marks the end of the frame;
- a loadable shift register carries the frame and computes the parity when it loads;
- a small control state machine drives load, shift and the two clears.

Top module: `ser7_tx`

## Requirements
- R1: After reset, `busy` is 0 and `txd` is 1.
- R2: When `send` is 1 while the transmitter is idle, `busy` is 1 in the next cycle and `txd` shows the start bit (0) in that same cycle.
- R3: The line carries the frame in this order: start (0), then `tx_data[0]` through `tx_data[6]`, then parity, then stop (1). Each bit holds for exactly `CLKS_PER_BIT` cycles.
- R4: With `par_sel` = 1 the parity bit is `~^tx_data`, which gives odd parity. With `par_sel` = 0 it is `^tx_data`, which gives even parity. Both are taken from the values present at load.
- R5: `busy` stays 1 for exactly 10 × `CLKS_PER_BIT` cycles and then falls.
- R6: While `send` stays high after `busy` falls, no new frame starts. A new frame starts only after `send` has been seen low for at least one cycle.
- R7: After load, changes on `tx_data` and `par_sel`, and a release of `send`, have no effect on the frame in progress.
- R8: `txd` is 1 in every cycle in which `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send | input | 1 | Host request; held high until `busy` falls |
| par_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| tx_data | input | 7 | Character to send |
| busy | output | 1 | High while a frame is on the line |
| txd | output | 1 | Serial line, idle high |

## Verification
The bound checker tests the following on every cycle:
- the line is high whenever `busy` is low;
- `busy` rises only on a request, and always with a start bit on the line;
- `busy` lasts exactly one frame length;
- no second frame starts until `send` has been released.

Only the bench scenarios can show the following:
- the bit order on the line;
- the parity value for each character and parity choice;
- that mid-frame changes on the inputs are ignored.

For these the bench sweeps all 128 characters under both parity settings.

// File: rtl/ser7_tx_pkg.sv
// Shared types for the serial character transmitter.
package ser7_tx_pkg;
    // Control states: idle, frame on the line, waiting for request release.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XMIT = 2'd1,
        ST_HOLD = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ser7_bit_timer.sv
// Bit-period timer. It produces a one-cycle tick every CLKS_PER_BIT cycles.
// Assumes CLKS_PER_BIT >= 2. A clear restarts the period from zero.
module ser7_bit_timer #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Tick on the last cycle of each period.
    assign tick = (cnt == LAST) && !clr;

    // Advance the period counter, wrapping on tick or restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ser7_bit_counter.sv
// Modulo-MOD frame position counter.
// `wrap` is high on the increment that ends the last position.
module ser7_bit_counter #(
    parameter int MOD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic wrap
);
    localparam int CW = $clog2(MOD);
    localparam logic [CW-1:0] LAST = CW'(MOD - 1);

    logic [CW-1:0] pos;

    // End of frame: the last position is being left.
    assign wrap = inc && (pos == LAST);

    // Track the current bit position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pos <= '0;
        else if (wrap)     pos <= '0;
        else if (inc)      pos <= pos + 1'b1;
    end
endmodule

// File: rtl/ser7_shifter.sv
// Frame shift register with a parity generator.
// On load it captures start, data, parity and stop. On shift it moves one bit
// toward the line and fills with ones, so it returns to idle-high by itself
// after a full frame. Assumes load and shift are never high together.
module ser7_shifter #(
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    output logic              ser_out
);
    localparam int FRAME_W = DATA_W + 3;

    logic [FRAME_W-1:0] sreg;
    logic               par_bit;

    // Parity generator: even parity is the XOR of the data; odd inverts it.
    assign par_bit = (^data) ^ odd;

    // Load a new frame, or shift one bit out with ones filling behind it.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '1;
        else if (load)  sreg <= {1'b1, par_bit, data, 1'b0};
        else if (shift) sreg <= {1'b1, sreg[FRAME_W-1:1]};
    end

    assign ser_out = sreg[0];
endmodule

// File: rtl/ser7_ctrl.sv
// Control state machine for the four-phase request/acknowledge exchange.
// It loads the frame on a request and sequences shifts on timer ticks.
// It waits for the request to drop after the frame before going idle again.
module ser7_ctrl
    import ser7_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic tick,
    input  logic last,
    output logic load,
    output logic shift,
    output logic tmr_clr,
    output logic cnt_clr,
    output logic busy
);
    tx_state_e state, nxt;

    // Output decode from the current state.
    always_comb begin
        load    = (state == ST_IDLE) && send;
        tmr_clr = load;
        cnt_clr = load;
        shift   = (state == ST_XMIT) && tick;
        busy    = (state == ST_XMIT);
    end

    // Next-state choice.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (send)          nxt = ST_XMIT;
            ST_XMIT: if (shift && last) nxt = ST_HOLD;
            ST_HOLD: if (!send)         nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/ser7_tx.sv
// Top level of the serial character transmitter.
// It connects the timer, the position counter, the shifter and the control.
// Assumes the host holds `send` high until `busy` falls.
module ser7_tx #(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic              par_sel,
    input  logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic              txd
);
    localparam int FRAME_BITS = DATA_W + 3;

    logic tick, last, load, shift, tmr_clr, cnt_clr;

    ser7_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
    );

    ser7_bit_counter #(.MOD(FRAME_BITS)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(shift), .wrap(last)
    );

    ser7_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .data(tx_data), .odd(par_sel), .ser_out(txd)
    );

    ser7_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .send(send), .tick(tick), .last(last),
        .load(load), .shift(shift), .tmr_clr(tmr_clr), .cnt_clr(cnt_clr),
        .busy(busy)
    );
endmodule

// File: rtl/ser7_tx_chk.sv
// Protocol checker for ser7_tx, bound to every instance.
// It measures the busy window with its own counter and tracks request release.
module ser7_tx_chk #(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_W       = 7
) (
    input logic clk,
    input logic rst_n,
    input logic send,
    input logic busy,
    input logic txd
);
    localparam int FRAME_LEN = (DATA_W + 3) * CLKS_PER_BIT;

    logic [31:0] busy_cyc;
    logic        released;

    // Count the cycles of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cyc <= '0;
        else                 busy_cyc <= busy_cyc + 1;
    end

    // Remember whether the request was seen low since the last frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     released <= 1'b1;
        else if (busy)  released <= 1'b0;
        else if (!send) released <= 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && txd)); // R1
    AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(send)); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd); // R2
    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (busy_cyc < FRAME_LEN)); // R5
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ($past(busy_cyc) == FRAME_LEN - 1)); // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(released)); // R6
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd); // R8
endmodule

bind ser7_tx ser7_tx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .send(send), .busy(busy), .txd(txd)
);

// File: tb/sim_ser7_tx.sv
// Sweeps every character under both parity settings and checks each line cycle.
module sim_ser7_tx;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 4;
    localparam int NBITS      = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send = 1'b0;
    logic       par_sel = 1'b0;
    logic [6:0] tx_data = '0;
    logic       busy, txd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser7_tx #(.CLKS_PER_BIT(CPB), .DATA_W(7)) u0 (
        .clk(clk), .rst_n(rst_n), .send(send), .par_sel(par_sel),
        .tx_data(tx_data), .busy(busy), .txd(txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Send one frame. In mode 1, change the inputs and drop send mid-frame (R7).
    task automatic frame(input logic [6:0] d, input logic p, input bit mode);
        logic [9:0] exp;
        logic par;
        par = (^d) ^ p;
        exp = {1'b1, par, d, 1'b0};
        @(negedge clk);
        send = 1'b1; tx_data = d; par_sel = p;
        for (int k = 0; k < NBITS; k++) begin
            for (int j = 0; j < CPB; j++) begin
                @(negedge clk);
                if (mode && k == 2 && j == 0) begin
                    tx_data = ~d; par_sel = ~p; send = 1'b0;
                end
                if (k == 0 && j == 0) chk(busy && !txd, "R2", {busy, txd}, 2);
                if (k == 8)
                    chk(txd == exp[k], mode ? "R7" : "R4", txd, exp[k]);
                else
                    chk(txd == exp[k], mode ? "R7" : "R3", txd, exp[k]);
                chk(busy == 1'b1, "R5", busy, 1);
            end
        end
        @(negedge clk);
        chk(!busy && txd, "R5", {busy, txd}, 1);
        if (!mode) begin
            for (int h = 0; h < 3; h++) begin
                @(negedge clk);
                chk(!busy && txd, "R6", {busy, txd}, 1);
            end
        end
        send = 1'b0;
        @(negedge clk);
        chk(!busy && txd, "R8", {busy, txd}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && txd, "R1", {busy, txd}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && txd, "R8", {busy, txd}, 1);
        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 128; d++)
                frame(7'(d), p[0], 1'b0);
        frame(7'h57, 1'b1, 1'b1);
        frame(7'h00, 1'b0, 1'b1);
        frame(7'h7F, 1'b1, 1'b0);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            report();
        end
    end
endmodule